// File: doc/BRIEF.md
# M/N:D Fractional Clock Divider

This block derives a slower clock enable from a source clock by two stages in series. An integer pre-divider first produces one tick every (P+1) source cycles. An M/N accumulator then passes on M of every N of those ticks, so the average enable rate is the source rate divided by (P+1), times M/N. A level output gives a clock-like waveform whose high time is set by a duty field. Everything is synchronous to the source clock, so downstream logic uses `clk_en` as a clock enable rather than as a derived clock.

The configuration arrives as register fields in their stored encoding. N is held as the complement of (N - M), and the duty field as the complement of a duty value. The mode field and the counter-enable bit choose between the M/N stage and a straight pre-divided output. A restart bit holds the whole divider quiet so that new values can be loaded without a partial cycle appearing at the outputs. When the bit is released, counting starts from zero with the values present at that moment.

Top module: `mnd_clk_divider`

## Requirements
- R1: With pre-divide field P, the pre-divider gives one tick every P+1 source cycles. The first tick falls on the (P+1)th rising edge after restart is released, and P = 0 means a tick on every cycle.
- R2: When the mode field is zero or the counter-enable bit is low, `clk_en` pulses for one cycle on every pre-divider tick and `clk_lvl` equals `clk_en`.
- R3: The true N is decoded as (~`cfg_n_enc` + `cfg_m`) modulo 2^W. The bench writes `cfg_n_enc` = ~(N - M) masked to W bits.
- R4: In M/N operation an accumulator starts at 0 after restart. On every tick it adds M. If the sum reaches N or more, N is subtracted and `clk_en` pulses, giving exactly M pulses per N ticks.
- R5: If M >= N in M/N operation, the accumulator is cleared and `clk_en` pulses on every tick.
- R6: A decoded N of zero makes the block behave as in R2, even with the mode and enable set.
- R7: The duty threshold is H = (~`cfg_d_enc` masked to W bits) >> 1. On each tick in M/N operation, `clk_lvl` becomes 1 when the updated accumulator is below H. Between ticks `clk_lvl` holds and `clk_en` is 0.
- R8: While `cfg_cnt_rst` is 1, and after `rst_n` is asserted, both outputs are 0 from the next edge and the internal counters are cleared. Field changes made during restart have no effect until release.
- R9: The mode values 1, 2 and 3 produce identical behaviour, as long as the mode is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_m | input | W | Multiplier M |
| cfg_n_enc | input | W | Stored N: complement of (N - M) |
| cfg_d_enc | input | W | Stored duty: complement of the duty value |
| cfg_prediv | input | PW | Pre-divide ratio minus one |
| cfg_mode | input | MW | Counter mode, zero selects bypass |
| cfg_cnt_en | input | 1 | Counter enable |
| cfg_cnt_rst | input | 1 | Counter restart hold |
| clk_en | output | 1 | One-cycle enable pulse at the output rate |
| clk_lvl | output | 1 | Duty-shaped level output |

## Verification
The bench runs the bypass path with several pre-divide values and with both ways of disabling the counter, which separates the pre-divider from the accumulator. It runs M/N ratios of 1/4 and 3/8 with and without pre-division; these show whether the wrap point, the subtraction of N and the decoding of the stored N are right, and a pulse count over a full period confirms the M-per-N rate. It also applies the corner inputs M = N and decoded N = 0, the alternate mode values, and field changes made while restart is held, each of which would give a different pulse train if handled wrongly.

// File: rtl/mnd_clk_divider.sv
module mnd_clk_divider #(
  parameter int W  = 8,
  parameter int PW = 4,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cfg_m,
  input  logic [W-1:0]  cfg_n_enc,
  input  logic [W-1:0]  cfg_d_enc,
  input  logic [PW-1:0] cfg_prediv,
  input  logic [MW-1:0] cfg_mode,
  input  logic          cfg_cnt_en,
  input  logic          cfg_cnt_rst,
  output logic          clk_en,
  output logic          clk_lvl
);
  logic [PW-1:0] pd_cnt;
  logic [W-1:0]  acc, acc_nxt, n_true, d_half, d_inv;
  logic [W:0]    sum;
  logic          pd_tick, mn_act, full, wrap;

  assign n_true  = ~cfg_n_enc + cfg_m;
  assign d_inv   = ~cfg_d_enc;
  assign d_half  = d_inv >> 1;
  assign pd_tick = (pd_cnt >= cfg_prediv);
  assign mn_act  = cfg_cnt_en && (cfg_mode != '0) && (n_true != '0);
  assign full    = (cfg_m >= n_true);
  assign sum     = {1'b0, acc} + {1'b0, cfg_m};
  assign wrap    = (sum >= {1'b0, n_true});

  always_comb begin
    if (full)      acc_nxt = '0;
    else if (wrap) acc_nxt = W'(sum - {1'b0, n_true});
    else           acc_nxt = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_cnt  <= '0;
      acc     <= '0;
      clk_en  <= 1'b0;
      clk_lvl <= 1'b0;
    end else if (cfg_cnt_rst) begin
      pd_cnt  <= '0;
      acc     <= '0;
      clk_en  <= 1'b0;
      clk_lvl <= 1'b0;
    end else begin
      pd_cnt <= pd_tick ? '0 : pd_cnt + PW'(1);
      if (mn_act) begin
        if (pd_tick) begin
          acc     <= acc_nxt;
          clk_en  <= full | wrap;
          clk_lvl <= (acc_nxt < d_half);
        end else begin
          clk_en  <= 1'b0;
        end
      end else begin
        acc     <= '0;
        clk_en  <= pd_tick;
        clk_lvl <= pd_tick;
      end
    end
  end
endmodule

module mnd_clk_divider_chk #(
  parameter int W  = 8,
  parameter int PW = 4,
  parameter int MW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  cfg_m,
  input logic [W-1:0]  cfg_n_enc,
  input logic [PW-1:0] cfg_prediv,
  input logic [MW-1:0] cfg_mode,
  input logic          cfg_cnt_en,
  input logic          cfg_cnt_rst,
  input logic          clk_en,
  input logic          clk_lvl,
  input logic          pd_tick
);
  logic [W-1:0] nt;
  logic         mnm;
  assign nt  = ~cfg_n_enc + cfg_m;
  assign mnm = cfg_cnt_en && (cfg_mode != '0) && (nt != '0);

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cnt_rst |=> (!clk_en && !clk_lvl)); // R8
  AST_BYPASS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!mnm && !cfg_cnt_rst) |=> (clk_lvl == clk_en)); // R2
  AST_PREDIV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mnm && !cfg_cnt_rst && cfg_prediv == '0) |=> clk_en); // R1
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mnm && !cfg_cnt_rst && pd_tick && cfg_m >= nt) |=> clk_en); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mnm && !cfg_cnt_rst && !pd_tick) |=> (!clk_en && $stable(clk_lvl))); // R7
endmodule

bind mnd_clk_divider mnd_clk_divider_chk #(.W(W), .PW(PW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_m(cfg_m), .cfg_n_enc(cfg_n_enc),
  .cfg_prediv(cfg_prediv), .cfg_mode(cfg_mode), .cfg_cnt_en(cfg_cnt_en),
  .cfg_cnt_rst(cfg_cnt_rst), .clk_en(clk_en), .clk_lvl(clk_lvl), .pd_tick(pd_tick)
);

// File: tb/mnd_clk_divider_test.sv
module mnd_clk_divider_test;
  localparam int W = 8, PW = 4, MW = 2;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] cfg_m = '0, cfg_n_enc = '0, cfg_d_enc = '0;
  logic [PW-1:0] cfg_prediv = '0;
  logic [MW-1:0] cfg_mode = '0;
  logic cfg_cnt_en = 1'b0, cfg_cnt_rst = 1'b0;
  logic clk_en, clk_lvl;

  int checks = 0, fails = 0, seen_pulses = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  mnd_clk_divider #(.W(W), .PW(PW), .MW(MW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_m(cfg_m), .cfg_n_enc(cfg_n_enc),
    .cfg_d_enc(cfg_d_enc), .cfg_prediv(cfg_prediv), .cfg_mode(cfg_mode),
    .cfg_cnt_en(cfg_cnt_en), .cfg_cnt_rst(cfg_cnt_rst),
    .clk_en(clk_en), .clk_lvl(clk_lvl));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (clk_en) seen_pulses++;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " outputs {en,lvl}"}, {30'd0, clk_en, clk_lvl}, {30'd0, e});
    end
  end

  function automatic int enc_n(int m, int n);
    return (~(n - m)) & MASK;
  endfunction

  task automatic run_case(string tag, int m, int n_enc, int d_enc, int p,
                          int mode, bit en, int cycles);
    int nt, half, acc, e, l;
    @(negedge clk);
    cfg_cnt_rst = 1'b1;
    cfg_m = W'(MASK - m);        // R8: values written during restart must not matter
    cfg_n_enc = W'(n_enc ^ 3);
    @(negedge clk);
    check({tag, " R8 held en"}, {31'd0, clk_en}, 0);
    check({tag, " R8 held lvl"}, {31'd0, clk_lvl}, 0);
    cfg_m = W'(m); cfg_n_enc = W'(n_enc); cfg_d_enc = W'(d_enc);
    cfg_prediv = PW'(p); cfg_mode = MW'(mode); cfg_cnt_en = en;
    @(negedge clk);
    check({tag, " R8 held en after reload"}, {31'd0, clk_en}, 0);
    nt = ((~n_enc) + m) & MASK;          // R3 decoding
    half = ((~d_enc) & MASK) >> 1;       // R7 threshold
    acc = 0; l = 0;
    for (int k = 1; k <= cycles; k++) begin
      bit tick;
      tick = (k % (p + 1)) == 0;         // R1
      if (!(en && mode != 0 && nt != 0)) begin
        e = tick; l = tick;              // R2 / R6
      end else if (tick) begin
        e = 0;
        if (m >= nt) begin acc = 0; e = 1; end   // R5
        else begin
          acc += m;                      // R4
          if (acc >= nt) begin acc -= nt; e = 1; end
        end
        l = (acc < half) ? 1 : 0;
      end else e = 0;
      exp_q.push_back({e[0], l[0]});
      tag_q.push_back(tag);
    end
    seen_pulses = 0;
    cfg_cnt_rst = 1'b0;
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset en", {31'd0, clk_en}, 0);
    check("R8 reset lvl", {31'd0, clk_lvl}, 0);
    rst_n = 1'b1;

    run_case("R2 bypass p0", 3, enc_n(3, 8), (~8) & MASK, 0, 0, 1'b1, 8);
    run_case("R1 bypass p3", 3, enc_n(3, 8), (~8) & MASK, 3, 2, 1'b0, 16);
    run_case("R4 R7 m1n4", 1, enc_n(1, 4), (~4) & MASK, 0, 2, 1'b1, 16);
    run_case("R3 R4 m3n8 p1", 3, enc_n(3, 8), (~8) & MASK, 1, 2, 1'b1, 32);
    check("R4 pulses over 16 ticks", seen_pulses, 6);
    run_case("R5 m5n5", 5, enc_n(5, 5), (~5) & MASK, 0, 2, 1'b1, 8);
    run_case("R6 n zero", 0, MASK, 0, 2, 2, 1'b1, 12);
    run_case("R9 mode1", 1, enc_n(1, 4), (~4) & MASK, 0, 1, 1'b1, 12);
    run_case("R9 mode3", 1, enc_n(1, 4), (~4) & MASK, 0, 3, 1'b1, 12);
    run_case("R7 m2n7 d6", 2, enc_n(2, 7), (~12) & MASK, 2, 2, 1'b1, 42);
    check("R4 pulses over 14 ticks", seen_pulses, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule